// File: doc/BRIEF.md
# Four-Leg Hysteresis Current Controller

This block turns sampled current errors into the eight gate commands of a four-leg shunt compensator inverter. Each of the three phase legs compares the measured compensator current with its reference. If the measurement is too high, the leg drives its lower switch. If it is too low, the leg drives its upper switch. While the error stays inside a band of plus or minus half the programmed width, the leg keeps whatever state it already has.

The fourth leg handles the neutral. The block forms the supply neutral current as the negated sum of the three supply phase currents. It then applies the same band rule to that current against a reference of zero. Every complementary pair passes through a break-before-make stage. That stage holds both gates low for a programmed number of clock cycles before the incoming switch turns on.

Currents are signed two's-complement integers in one common scale. With 1 LSB = 1 mA, the usual band setting of 0.2 A is `band = 200`. The half band is `floor(band/2)`. The decision in each leg is a demand with three values: NONE, UPPER and LOWER. The break-before-make stage in each leg is a state machine with four states: OFF, DEAD, UPPER and LOWER.

State transitions:
- OFF→UPPER and OFF→LOWER happen on the first UPPER or LOWER demand, with no dead time.
- UPPER→DEAD and LOWER→DEAD happen on an opposite demand when the dead time is non-zero.
- UPPER→LOWER and LOWER→UPPER happen directly on an opposite demand when the dead time is zero.
- DEAD→UPPER or DEAD→LOWER, following the current demand, happens once the dead-time count is reached.

Top module: `hbcc_four_leg`

## Requirements
- R1: After reset all eight gates are low, and they stay low until a strobed comparison produces a demand outside the band. A sample lying inside the band leaves them low.
- R2: On a strobe where `meas - ref >= floor(band/2)`, the leg demands its lower switch on and its upper switch off. The comparison includes equality.
- R3: On a strobe where `meas - ref <= -floor(band/2)`, the leg demands its upper switch on and its lower switch off. The comparison includes equality.
- R4: On a strobe where the error lies strictly inside the band, the leg keeps its previous gate state unchanged.
- R5: Input changes made while `sample_en` is low have no effect on any gate.
- R6: Leg 3 (gate bit 3) applies the rules of R2 to R4 to `-(isup_a + isup_b + isup_c)` against a zero reference. Legs 0, 1 and 2 (gate bits 0, 1, 2) serve phases a, b and c.
- R7: When a leg reverses, both of its gates are low for exactly `dead_cycles` clock cycles before the incoming gate rises. With `dead_cycles = 0` the leg swaps in a single cycle.
- R8: The upper and lower gates of one leg are never high at the same time.
- R9: A strobe sampled at clock edge S changes the gates at edge S+1 at the earliest. The gates hold their old values until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Strobe: evaluate comparisons this cycle |
| band | input | BAND_W | Full hysteresis width, unsigned |
| dead_cycles | input | DT_W | Break-before-make length in clock cycles |
| cref_a | input | CUR_W | Phase a compensator reference current, signed |
| cref_b | input | CUR_W | Phase b compensator reference current, signed |
| cref_c | input | CUR_W | Phase c compensator reference current, signed |
| cmeas_a | input | CUR_W | Phase a measured compensator current, signed |
| cmeas_b | input | CUR_W | Phase b measured compensator current, signed |
| cmeas_c | input | CUR_W | Phase c measured compensator current, signed |
| isup_a | input | CUR_W | Phase a supply current, signed |
| isup_b | input | CUR_W | Phase b supply current, signed |
| isup_c | input | CUR_W | Phase c supply current, signed |
| gate_hi | output | 4 | Upper gate per leg (bits a, b, c, neutral) |
| gate_lo | output | 4 | Lower gate per leg (bits a, b, c, neutral) |

## Verification
The strobe is registered into a demand at edge S. The gate state machine acts on that demand at edge S+1. The bench therefore expects the old gates one cycle after the strobe, and the new or dead (all low) value two cycles after it. For a reversal with a dead time of D cycles, the incoming gate is due at cycle S+1+D, and the last dead cycle at S+D is checked as well. The driver tags each expected vector with its due cycle. The monitor compares that vector on the falling edge of exactly that cycle, and counts any vector whose cycle has passed as a failure.

// File: rtl/hbcc_pkg.sv
package hbcc_pkg;
    localparam int NUM_LEGS = 4;

    typedef enum logic [1:0] {
        DM_NONE,
        DM_UPPER,
        DM_LOWER
    } demand_t;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_DEAD,
        ST_UPPER,
        ST_LOWER
    } leg_state_t;
endpackage

// File: rtl/hbcc_band_cmp.sv
module hbcc_band_cmp
    import hbcc_pkg::*;
#(
    parameter int IN_W   = 18,
    parameter int BAND_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_en,
    input  logic [BAND_W-1:0]        band,
    input  logic signed [IN_W-1:0]   meas,
    input  logic signed [IN_W-1:0]   target,
    output demand_t                  demand
);
    localparam int EW = IN_W + 2;

    logic signed [EW-1:0] err;
    logic signed [EW-1:0] half_pos;
    logic signed [EW-1:0] half_neg;

    assign err      = {{(EW-IN_W){meas[IN_W-1]}}, meas}
                    - {{(EW-IN_W){target[IN_W-1]}}, target};
    assign half_pos = $signed({{(EW-BAND_W+1){1'b0}}, band[BAND_W-1:1]});
    assign half_neg = -half_pos;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            demand <= DM_NONE;
        end else if (sample_en) begin
            if (err >= half_pos) begin
                demand <= DM_LOWER;
            end else if (err <= half_neg) begin
                demand <= DM_UPPER;
            end
        end
    end
endmodule

// File: rtl/hbcc_leg_fsm.sv
module hbcc_leg_fsm
    import hbcc_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  demand_t         demand,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            g_hi,
    output logic            g_lo
);
    leg_state_t      state, state_nx;
    logic [DT_W-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (demand == DM_UPPER)      state_nx = ST_UPPER;
                else if (demand == DM_LOWER) state_nx = ST_LOWER;
            end
            ST_UPPER: begin
                if (demand == DM_LOWER)
                    state_nx = (dead_cycles == '0) ? ST_LOWER : ST_DEAD;
            end
            ST_LOWER: begin
                if (demand == DM_UPPER)
                    state_nx = (dead_cycles == '0) ? ST_UPPER : ST_DEAD;
            end
            ST_DEAD: begin
                if (cnt >= dead_cycles) begin
                    if (demand == DM_UPPER)      state_nx = ST_UPPER;
                    else if (demand == DM_LOWER) state_nx = ST_LOWER;
                    else                         state_nx = ST_OFF;
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_DEAD && state != ST_DEAD) begin
                cnt <= DT_W'(1);
            end else if (state == ST_DEAD) begin
                cnt <= cnt + DT_W'(1);
            end
        end
    end

    always_comb begin
        g_hi = 1'b0;
        g_lo = 1'b0;
        unique case (state)
            ST_UPPER: g_hi = 1'b1;
            ST_LOWER: g_lo = 1'b1;
            default: begin
                g_hi = 1'b0;
                g_lo = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hbcc_four_leg.sv
module hbcc_four_leg
    import hbcc_pkg::*;
#(
    parameter int CUR_W  = 16,
    parameter int BAND_W = 16,
    parameter int DT_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic [BAND_W-1:0]       band,
    input  logic [DT_W-1:0]         dead_cycles,
    input  logic signed [CUR_W-1:0] cref_a,
    input  logic signed [CUR_W-1:0] cref_b,
    input  logic signed [CUR_W-1:0] cref_c,
    input  logic signed [CUR_W-1:0] cmeas_a,
    input  logic signed [CUR_W-1:0] cmeas_b,
    input  logic signed [CUR_W-1:0] cmeas_c,
    input  logic signed [CUR_W-1:0] isup_a,
    input  logic signed [CUR_W-1:0] isup_b,
    input  logic signed [CUR_W-1:0] isup_c,
    output logic [3:0]              gate_hi,
    output logic [3:0]              gate_lo
);
    localparam int IN_W = CUR_W + 2;

    logic signed [IN_W-1:0] leg_meas   [NUM_LEGS];
    logic signed [IN_W-1:0] leg_target [NUM_LEGS];
    logic signed [IN_W-1:0] isup_sum;
    demand_t                leg_demand [NUM_LEGS];

    assign isup_sum = IN_W'(isup_a) + IN_W'(isup_b) + IN_W'(isup_c);

    assign leg_meas[0]   = IN_W'(cmeas_a);
    assign leg_meas[1]   = IN_W'(cmeas_b);
    assign leg_meas[2]   = IN_W'(cmeas_c);
    assign leg_meas[3]   = -isup_sum;
    assign leg_target[0] = IN_W'(cref_a);
    assign leg_target[1] = IN_W'(cref_b);
    assign leg_target[2] = IN_W'(cref_c);
    assign leg_target[3] = '0;

    for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
        hbcc_band_cmp #(
            .IN_W  (IN_W),
            .BAND_W(BAND_W)
        ) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_en(sample_en),
            .band     (band),
            .meas     (leg_meas[k]),
            .target   (leg_target[k]),
            .demand   (leg_demand[k])
        );

        hbcc_leg_fsm #(
            .DT_W(DT_W)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .demand     (leg_demand[k]),
            .dead_cycles(dead_cycles),
            .g_hi       (gate_hi[k]),
            .g_lo       (gate_lo[k])
        );
    end
endmodule

// File: rtl/hbcc_four_leg_chk.sv
module hbcc_four_leg_chk #(
    parameter int DT_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sample_en,
    input logic [DT_W-1:0] dead_cycles,
    input logic [3:0]      gate_hi,
    input logic [3:0]      gate_lo
);
    logic seen_sample;

    always_ff @(posedge clk) begin
        if (!rst_n)         seen_sample <= 1'b0;
        else if (sample_en) seen_sample <= 1'b1;
    end

    assert_off_until_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_sample |-> (gate_hi == 4'b0 && gate_lo == 4'b0));

    for (genvar k = 0; k < 4; k++) begin : g_chk
        assert_no_shoot_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi[k] && gate_lo[k]));

        assert_break_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_hi[k]) && $past(dead_cycles) != '0) |-> !$past(gate_lo[k]));

        assert_break_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_lo[k]) && $past(dead_cycles) != '0) |-> !$past(gate_hi[k]));
    end
endmodule

bind hbcc_four_leg hbcc_four_leg_chk #(.DT_W(DT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .dead_cycles(dead_cycles),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo)
);

// File: tb/test_hbcc_four_leg.sv
module test_hbcc_four_leg;
    typedef struct {
        int         due;
        logic [3:0] hi;
        logic [3:0] lo;
        string      tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_en = 1'b0;
    logic [15:0]       band = 16'd200;
    logic [7:0]        dead_cycles = 8'd3;
    logic signed [15:0] cref_a = '0, cref_b = '0, cref_c = '0;
    logic signed [15:0] cmeas_a = '0, cmeas_b = '0, cmeas_c = '0;
    logic signed [15:0] isup_a = '0, isup_b = '0, isup_c = '0;
    logic [3:0]        gate_hi, gate_lo;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   mst [4] = '{0, 0, 0, 0};
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hbcc_four_leg i_hbcc_four_leg (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
        .band(band), .dead_cycles(dead_cycles),
        .cref_a(cref_a), .cref_b(cref_b), .cref_c(cref_c),
        .cmeas_a(cmeas_a), .cmeas_b(cmeas_b), .cmeas_c(cmeas_c),
        .isup_a(isup_a), .isup_b(isup_b), .isup_c(isup_c),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    function automatic logic [3:0] hi_of(input int s[4]);
        for (int k = 0; k < 4; k++) hi_of[k] = (s[k] == 1);
    endfunction

    function automatic logic [3:0] lo_of(input int s[4]);
        for (int k = 0; k < 4; k++) lo_of[k] = (s[k] == 2);
    endfunction

    task automatic push(input int due, input logic [3:0] hi, input logic [3:0] lo, input string tag);
        exp_t e;
        e.due = due; e.hi = hi; e.lo = lo; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares each expected vector on the falling edge of its due cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.due < cyc) begin
                errors++;
                $display("FAIL %s: check due at cycle %0d missed (now %0d)", e.tag, e.due, cyc);
            end else if (gate_hi !== e.hi || gate_lo !== e.lo) begin
                errors++;
                $display("FAIL %s: cycle %0d hi=%b lo=%b expected hi=%b lo=%b",
                         e.tag, cyc, gate_hi, gate_lo, e.hi, e.lo);
            end
        end
    end

    // Driver: called at a falling edge; applies one strobed sample and queues expectations
    task automatic do_sample(input int ra, input int rb, input int rc,
                             input int ma, input int mb, input int mc,
                             input int sa, input int sb, input int sc,
                             input string tag);
        int half, d, c, err;
        int nst [4];
        int mid [4];
        bit any_sw;
        half   = int'(band) / 2;
        d      = int'(dead_cycles);
        c      = cyc;
        any_sw = 0;
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: err = ma - ra;
                1: err = mb - rb;
                2: err = mc - rc;
                default: err = -(sa + sb + sc);
            endcase
            nst[k] = mst[k];
            if (err >= half)       nst[k] = 2;
            else if (err <= -half) nst[k] = 1;
            if (mst[k] != 0 && nst[k] != mst[k] && d > 0) begin
                mid[k] = 0;
                any_sw = 1;
            end else begin
                mid[k] = nst[k];
            end
        end
        cref_a = 16'(ra); cref_b = 16'(rb); cref_c = 16'(rc);
        cmeas_a = 16'(ma); cmeas_b = 16'(mb); cmeas_c = 16'(mc);
        isup_a = 16'(sa); isup_b = 16'(sb); isup_c = 16'(sc);
        sample_en = 1'b1;
        push(c + 1, hi_of(mst), lo_of(mst), {tag, " R9 old state held"});
        push(c + 2, hi_of(mid), lo_of(mid), tag);
        if (any_sw) begin
            if (d > 1) push(c + 1 + d, hi_of(mid), lo_of(mid), {tag, " R7 last dead cycle"});
            push(c + 2 + d, hi_of(nst), lo_of(nst), {tag, " R7 after dead time"});
        end
        mst = nst;
        @(negedge clk);
        sample_en = 1'b0;
        repeat (d + 4) @(negedge clk);
    endtask

    // Changes inputs without a strobe; the gates must not move (R5)
    task automatic idle_change(input int v);
        int c;
        c = cyc;
        cmeas_a = 16'(v);  cmeas_b = 16'(-v); cmeas_c = 16'(v);
        isup_a  = 16'(v);  isup_b  = 16'(v);  isup_c  = 16'(v);
        for (int i = 1; i <= 5; i++) push(c + i, hi_of(mst), lo_of(mst), "R5 no strobe, no change");
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        for (int i = 0; i <= 1; i++) push(cyc + i, 4'b0, 4'b0, "R1 gates low in reset");
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 1; i <= 3; i++) push(cyc + i, 4'b0, 4'b0, "R1 gates low after reset");
        repeat (4) @(negedge clk);

        // R1/R4: inside band everywhere keeps all gates off (neutral isn = 10)
        do_sample(1000, -500, 0, 1050, -450, -99, 10, 20, -40, "R1 R4 inside band stays off");
        // R2 boundary +half, R3 boundary -half, R6 neutral isn=-300 -> upper
        do_sample(1000, -500, 0, 1100, -600, 500, 100, 100, 100, "R2 R3 R6 first demands");
        // R4: all errors strictly inside band -> hold
        do_sample(1000, -500, 0, 1099, -401, 99, -30, 0, 0, "R4 hold inside band");
        // R7 dead time 3: reverse all legs, neutral isn=150 -> lower
        do_sample(1000, -500, 0, 850, -399, -100, -50, -50, -50, "R7 R6 reversal with dead time 3");
        // R5: no strobe, inputs far outside band
        idle_change(20000);
        // R7 zero dead time: direct swap
        dead_cycles = 8'd0;
        @(negedge clk);
        do_sample(0, 0, 0, 300, 300, 300, 200, 0, 0, "R7 R2 direct swap with dead time 0");
        // R7 one-cycle dead time
        dead_cycles = 8'd1;
        @(negedge clk);
        do_sample(0, 0, 0, -300, 300, -300, -200, 0, 0, "R7 R3 reversal with dead time 1");
        // Extremes: neutral isn = 98304 -> lower; phase error -65535 -> upper
        dead_cycles = 8'd5;
        @(negedge clk);
        do_sample(32767, -32768, 0, -32768, 32767, 0, -32768, -32768, -32768,
                  "R6 R2 R3 extreme values");
        // Narrow band 2 (half 1): error 0 inside, error 1 at edge
        band = 16'd2;
        @(negedge clk);
        do_sample(10, 10, 10, 10, 11, 9, 0, 0, -1, "R4 R2 R3 narrow band edges");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule